// File: doc/BRIEF.md
# Two-Entry Overwrite Receive Buffer

This block holds received CAN frames for the final, receive-only message slot of a CAN controller. It keeps up to two complete frames, each with its identifier, its standard/extended format flag, its byte count and up to eight data bytes. It has no transmit path. The receiver hands over fully assembled frames on a one-cycle push strobe. The host always sees the oldest frame on the head outputs, and releases it with a pop strobe.

When a frame arrives while both entries are still unread, it replaces the newer entry and leaves the older entry untouched. A sticky overrun flag records this event. An occupancy count and a not-empty flag let the host poll the buffer or take a receive interrupt.

Top module: `rx_pair_buffer`

## Requirements
- R1: After reset, `count` is 0, `not_empty` is 0 and `overrun` is 0.
- R2: Frames pushed into a buffer holding fewer than two entries are kept in arrival order, and the head outputs show the oldest stored frame from the cycle after the push.
- R3: A pop while `count` is 1 or 2 releases the head entry and lowers `count` by one. The second entry then appears on the head outputs.
- R4: A pop while `count` is 0 is ignored, and `count`, `overrun` and the head outputs stay unchanged.
- R5: A push without a pop while `count` is 2 replaces the second entry with the new frame. The head entry is unchanged and `count` stays 2.
- R6: The overwrite in R5 sets `overrun`, which then stays 1 until a cycle with `clr_ovr` high. If an overwrite and `clr_ovr` happen in the same cycle, `overrun` ends up 1.
- R7: A push and a pop in the same cycle while `count` is 2 first release the head entry and then store the new frame as the second entry. `count` stays 2 and `overrun` is not set.
- R8: A push and a pop in the same cycle while `count` is 1 make the new frame the head, and `count` stays 1.
- R9: A frame pushed with `push_ext` = 0 is stored with identifier bits 28..11 forced to zero. A frame pushed with `push_ext` = 1 keeps all 29 identifier bits.
- R10: A `push_dlc` above 8 is stored as 8. Data byte k is `push_data[8k+7:8k]`, and every byte with index k not below the stored byte count is stored as zero.
- R11: `not_empty` is 1 exactly when `count` is nonzero, `count` never exceeds 2, and every head output reads zero while `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Frame strobe from the receiver, one cycle per frame |
| push_id | input | 29 | Received identifier; only bits 10..0 are used for standard frames |
| push_ext | input | 1 | 1 = extended (29-bit) identifier, 0 = standard (11-bit) |
| push_dlc | input | 4 | Received data byte count |
| push_data | input | 64 | Data bytes; byte k is in bits 8k+7..8k |
| pop | input | 1 | Host releases the head entry |
| clr_ovr | input | 1 | Host write-one-to-clear of the overrun flag |
| head_id | output | 29 | Identifier of the oldest stored frame |
| head_ext | output | 1 | Format flag of the oldest stored frame |
| head_dlc | output | 4 | Byte count of the oldest stored frame |
| head_data | output | 64 | Data bytes of the oldest stored frame |
| count | output | 2 | Number of stored frames, 0 to 2 |
| not_empty | output | 1 | At least one frame is stored; receive interrupt |
| overrun | output | 1 | Sticky flag, set when a frame overwrote an unread entry |

## Verification
The properties assume that `push_valid`, `pop` and `clr_ovr` are sampled as clean single-cycle strobes at the rising edge. They also assume that the push fields are only meaningful in cycles where `push_valid` is high. The bench drives every input half a period away from the active edge, so each strobe is seen in exactly one cycle. Its random phase mixes pushes, pops and clears freely, including pops on an empty buffer and simultaneous push/pop at every fill level. Byte counts run from 0 to 15, so the clamp of R10 is exercised as well.

// File: rtl/rx_pair_buffer.sv
module rx_pair_buffer #(
  parameter int ID_W      = 29,
  parameter int STD_ID_W  = 11,
  parameter int MAX_BYTES = 8,
  parameter int DLC_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_valid,
  input  logic [ID_W-1:0]        push_id,
  input  logic                   push_ext,
  input  logic [DLC_W-1:0]       push_dlc,
  input  logic [MAX_BYTES*8-1:0] push_data,
  input  logic                   pop,
  input  logic                   clr_ovr,
  output logic [ID_W-1:0]        head_id,
  output logic                   head_ext,
  output logic [DLC_W-1:0]       head_dlc,
  output logic [MAX_BYTES*8-1:0] head_data,
  output logic [1:0]             count,
  output logic                   not_empty,
  output logic                   overrun
);

  localparam int DATA_W = MAX_BYTES * 8;

  logic [ID_W-1:0]   id_q   [2];
  logic              ext_q  [2];
  logic [DLC_W-1:0]  dlc_q  [2];
  logic [DATA_W-1:0] data_q [2];
  logic [1:0]        cnt_q;
  logic              ovr_q;

  logic [ID_W-1:0]   in_id;
  logic [DLC_W-1:0]  in_dlc;
  logic [DATA_W-1:0] in_data;

  assign in_id  = push_ext ? push_id
                           : {{(ID_W-STD_ID_W){1'b0}}, push_id[STD_ID_W-1:0]};
  assign in_dlc = (push_dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : push_dlc;

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    assign in_data[b*8 +: 8] = (DLC_W'(b) < in_dlc) ? push_data[b*8 +: 8] : 8'h00;
  end

  logic       do_pop;
  logic [1:0] base;
  logic       ovf;
  logic       wr_second;

  assign do_pop    = pop && (cnt_q != 2'd0);
  assign base      = cnt_q - {1'b0, do_pop};
  assign ovf       = push_valid && (base == 2'd2);
  assign wr_second = ovf || (base == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        id_q[i]   <= '0;
        ext_q[i]  <= 1'b0;
        dlc_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (do_pop) begin
        id_q[0]   <= id_q[1];
        ext_q[0]  <= ext_q[1];
        dlc_q[0]  <= dlc_q[1];
        data_q[0] <= data_q[1];
      end
      if (push_valid) begin
        if (wr_second) begin
          id_q[1]   <= in_id;
          ext_q[1]  <= push_ext;
          dlc_q[1]  <= in_dlc;
          data_q[1] <= in_data;
        end else begin
          id_q[0]   <= in_id;
          ext_q[0]  <= push_ext;
          dlc_q[0]  <= in_dlc;
          data_q[0] <= in_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= (push_valid && !ovf) ? base + 2'd1 : base;
      if (ovf)          ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;
    end
  end

  assign not_empty = (cnt_q != 2'd0);
  assign count     = cnt_q;
  assign overrun   = ovr_q;
  assign head_id   = not_empty ? id_q[0]   : '0;
  assign head_ext  = not_empty ? ext_q[0]  : 1'b0;
  assign head_dlc  = not_empty ? dlc_q[0]  : '0;
  assign head_data = not_empty ? data_q[0] : '0;

endmodule

// File: rtl/rx_pair_buffer_chk.sv
module rx_pair_buffer_chk #(
  parameter int ID_W   = 29,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              pop,
  input logic              clr_ovr,
  input logic [1:0]        count,
  input logic              not_empty,
  input logic              overrun,
  input logic [ID_W-1:0]   head_id,
  input logic [DATA_W-1:0] head_data
);

  // R11
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count != 2'd3);

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_empty == (count != 2'd0));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 2'd0 && pop && !push_valid) |=> (count == 2'd0));

  // R5
  overwrite_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 2'd2 && push_valid && !pop) |=> (count == 2'd2 && $stable(head_id) && $stable(head_data)));

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 2'd2 && push_valid && !pop) |=> overrun);

  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_ovr) |=> overrun);

  // R7
  swap_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 2'd2 && push_valid && pop && !overrun) |=> (!overrun && count == 2'd2));

  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != 2'd0 && pop && !push_valid) |=> (count == $past(count) - 2'd1));

endmodule

bind rx_pair_buffer rx_pair_buffer_chk #(.ID_W(ID_W), .DATA_W(MAX_BYTES*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop(pop), .clr_ovr(clr_ovr),
  .count(count), .not_empty(not_empty), .overrun(overrun),
  .head_id(head_id), .head_data(head_data)
);

// File: tb/rx_pair_buffer_bench.sv
module rx_pair_buffer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [28:0] push_id = '0;
  logic        push_ext = 1'b0;
  logic [3:0]  push_dlc = '0;
  logic [63:0] push_data = '0;
  logic        pop = 1'b0;
  logic        clr_ovr = 1'b0;
  logic [28:0] head_id;
  logic        head_ext;
  logic [3:0]  head_dlc;
  logic [63:0] head_data;
  logic [1:0]  count;
  logic        not_empty;
  logic        overrun;

  rx_pair_buffer u_rx_pair_buffer (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_id(push_id),
    .push_ext(push_ext), .push_dlc(push_dlc), .push_data(push_data),
    .pop(pop), .clr_ovr(clr_ovr), .head_id(head_id), .head_ext(head_ext),
    .head_dlc(head_dlc), .head_data(head_data), .count(count),
    .not_empty(not_empty), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  typedef struct { logic [28:0] id; logic ext; logic [3:0] dlc; logic [63:0] data; } frame_t;
  frame_t q[$];
  bit m_ovr = 0;

  function automatic frame_t norm(logic [28:0] id, logic ext, logic [3:0] dlc, logic [63:0] data);
    frame_t f;
    f.ext  = ext;
    f.id   = ext ? id : (id & 29'h7FF);
    f.dlc  = (dlc > 8) ? 4'd8 : dlc;
    f.data = '0;
    for (int k = 0; k < 8; k++)
      if (k < f.dlc) f.data[8*k +: 8] = data[8*k +: 8];
    return f;
  endfunction

  task automatic check(string what);
    frame_t e;
    logic [1:0] ec;
    e = '{id: '0, ext: 1'b0, dlc: '0, data: '0};
    if (q.size() > 0) e = q[0];
    ec = 2'(q.size());
    total++;
    if (count !== ec || not_empty !== (q.size() > 0) || overrun !== m_ovr ||
        head_id !== e.id || head_ext !== e.ext || head_dlc !== e.dlc || head_data !== e.data) begin
      bad++;
      $display("FAIL %s %s: got cnt=%0d ne=%0b ovr=%0b id=%h ext=%0b dlc=%0d data=%h exp cnt=%0d ne=%0b ovr=%0b id=%h ext=%0b dlc=%0d data=%h",
               tag, what, count, not_empty, overrun, head_id, head_ext, head_dlc, head_data,
               ec, q.size() > 0, m_ovr, e.id, e.ext, e.dlc, e.data);
    end
  endtask

  task automatic step(bit pu, bit po, bit cl, logic [28:0] id, logic ext, logic [3:0] dlc, logic [63:0] data);
    bit ovf;
    frame_t f;
    push_valid = pu; pop = po; clr_ovr = cl;
    push_id = id; push_ext = ext; push_dlc = dlc; push_data = data;
    @(posedge clk);
    f = norm(id, ext, dlc, data);
    ovf = 0;
    if (po && q.size() > 0) void'(q.pop_front());
    if (pu) begin
      if (q.size() == 2) begin q[1] = f; ovf = 1; end
      else q.push_back(f);
    end
    if (ovf) m_ovr = 1;
    else if (cl) m_ovr = 0;
    @(negedge clk);
    push_valid = 0; pop = 0; clr_ovr = 0;
    check("cycle");
  endtask

  task automatic sp(bit pu, bit po, bit cl, int s);
    step(pu, po, cl, 29'(s * 32'h9E3779B1), s[0], 4'(s % 16),
         {32'(s * 32'h85EBCA6B), 32'(s * 32'hC2B2AE35)});
  endtask

  initial begin
    #(4 * 20000);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; check("reset");
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; check("after release");
    tag = "R4"; sp(0, 1, 0, 3);
    tag = "R2"; sp(1, 0, 0, 11); sp(1, 0, 0, 22);
    tag = "R5"; sp(1, 0, 0, 37);
    tag = "R6"; sp(0, 0, 0, 1);
    tag = "R5"; sp(1, 0, 1, 41);
    tag = "R6"; sp(0, 0, 1, 2);
    tag = "R7"; sp(1, 1, 0, 52);
    tag = "R3"; sp(0, 1, 0, 4); sp(0, 1, 0, 5);
    tag = "R4"; sp(0, 1, 1, 6);
    tag = "R8"; sp(1, 0, 0, 61); sp(1, 1, 0, 63);
    tag = "R11"; sp(0, 1, 0, 7);
    tag = "R9"; step(1, 0, 0, 29'h1FFF_FFFF, 1'b0, 4'd8, 64'h0123_4567_89AB_CDEF);
    tag = "R9"; step(1, 0, 0, 29'h1ABC_DEF1, 1'b1, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    tag = "R10"; step(1, 1, 0, 29'h155, 1'b0, 4'd13, 64'hDEAD_BEEF_CAFE_F00D);
    tag = "R10"; step(1, 1, 0, 29'h2AA, 1'b0, 4'd3, 64'hDEAD_BEEF_CAFE_F00D);
    tag = "R10"; step(0, 1, 0, 0, 1'b0, 4'd0, 64'h0);
    tag = "R10"; step(1, 0, 0, 29'h7, 1'b1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    tag = "R2";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = (i * 7 + 3) % 11;
      sp(r < 6, (r % 3) == 0, r == 10, 100 + i * 13);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule